// File: doc/BRIEF.md
# MDIO Management Master

This block drives a clause 22 management bus to one or more Ethernet PHYs. Software uses a single 32-bit access register. The register holds these fields:

- a 5-bit PHY address
- a 5-bit register number
- a direction bit
- 16 bits of data
- a combined go/busy bit

A write to the register with the go bit clear only stores the fields. Repeating the same value with the go bit set launches a frame on MDC/MDIO.

While the frame runs, the go bit reads back as 1, and it drops to 0 on the clock where the last bit period ends. For a read, the 16 bits returned by the PHY then sit in the low half of the register. The MDC rate is set by the `DIV` parameter: each half period of MDC lasts `DIV` system clocks. Software polls the busy bit and must not issue a new command until that bit is clear.

Top module: `mdio_master`

## Requirements
- R1: After reset the register reads 0, MDC is low and the MDIO output enable is low.
- R2: A register write with bit 31 clear only stores the fields. The readback layout is:
  - bit 30: write select
  - bits 28:24: PHY address
  - bits 20:16: register number
  - bits 15:0: data
  - bits 29 and 23:21: always read 0
- R3: A write with bit 31 set, issued while idle, starts a frame. Bit 31 then reads 1 for exactly 128*DIV system clocks.
- R4: MDC is low while idle. During a frame, MDC toggles every DIV clocks, starting low.
- R5: Each frame is 64 bits, most significant bit first, changing only when MDC falls. The bits are:
  - 32 ones
  - 01
  - opcode: 01 for write, 10 for read
  - address
  - register
  - turnaround 10
  - 16 data bits
- R6: On a read, the output enable goes low from bit 46 (the turnaround) to the end of the frame. The output enable is low whenever the block is idle.
- R7: On a read, MDIO is sampled on each rising MDC edge of bits 48..63. The 16-bit result is in bits 15:0 once bit 31 has cleared.
- R8: A register write while bit 31 reads 1 is ignored. This includes the clock on which the frame completes. The frame continues and the stored fields remain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the access register |
| reg_wdata | input | 32 | Value written to the access register |
| reg_rdata | output | 32 | Current access register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
A register write and the completion of a frame can land on the same clock edge. The bench reproduces this by raising the write strobe exactly at the edge where the final MDC fall clears busy. The block must ignore that write, so busy must stay low afterwards and the stored fields must remain as they were. A second case sends writes in the middle of a frame; it is judged by comparing MDC, MDIO and busy against the reference model on every clock.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CW       = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int LAST_IDX = 63;
  localparam int TA_IDX   = 46;
  localparam int DATA_IDX = 48;

  logic          busy, wr_op;
  logic [4:0]    phy, rg;
  logic [15:0]   dat;
  logic [CW-1:0] divc;
  logic [5:0]    idx;
  logic [63:0]   sh;

  wire tick = busy && (divc == CW'(DIV - 1));
  wire rise = tick && !mdc;
  wire fall = tick && mdc;
  wire nwr  = reg_wdata[30];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      wr_op <= 1'b0;
      phy   <= '0;
      rg    <= '0;
      dat   <= '0;
      divc  <= '0;
      idx   <= '0;
      sh    <= '0;
      mdc   <= 1'b0;
    end else if (!busy) begin
      if (reg_wr) begin
        wr_op <= nwr;
        phy   <= reg_wdata[28:24];
        rg    <= reg_wdata[20:16];
        dat   <= reg_wdata[15:0];
        if (reg_wdata[31]) begin
          busy <= 1'b1;
          divc <= '0;
          idx  <= '0;
          mdc  <= 1'b0;
          sh   <= {32'hFFFF_FFFF, 2'b01, nwr ? 2'b01 : 2'b10,
                   reg_wdata[28:24], reg_wdata[20:16], 2'b10, reg_wdata[15:0]};
        end
      end
    end else begin
      divc <= tick ? '0 : divc + 1'b1;
      if (tick) mdc <= ~mdc;
      if (rise && !wr_op && idx >= 6'(DATA_IDX)) dat <= {dat[14:0], mdio_i};
      if (fall) begin
        sh <= {sh[62:0], 1'b1};
        if (idx == 6'(LAST_IDX)) busy <= 1'b0;
        else idx <= idx + 1'b1;
      end
    end
  end

  assign mdio_oe   = busy && (wr_op || idx < 6'(TA_IDX));
  assign mdio_o    = busy ? sh[63] : 1'b0;
  assign reg_rdata = {busy, wr_op, 1'b0, phy, 3'b000, rg, dat};
endmodule

module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  wire bsy = reg_rdata[31];

  assert_idle_oe_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bsy |-> !mdio_oe);
  assert_idle_mdc_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !bsy |-> !mdc);
  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bsy && reg_wr && reg_wdata[31]) |=> bsy);
  assert_fields_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && $past(bsy)) |-> $stable(reg_rdata[30:16]));
  assert_change_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$fell(mdc)) |-> $stable(mdio_o));
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[29] == 1'b0 && reg_rdata[23:21] == 3'b000);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
  localparam int D = 2;
  localparam int FRAME_CYC = 128 * D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  bit          m_busy = 1'b0;
  bit          m_wr   = 1'b0;
  int          j      = 0;
  logic [63:0] m_frame = '0;
  logic [15:0] pat = 16'hB00F;

  mdio_master #(.DIV(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (m_busy) begin
        j++;
        if (j == FRAME_CYC) m_busy = 1'b0;
      end else if (reg_wr && reg_wdata[31]) begin
        m_busy  = 1'b1;
        j       = 0;
        m_wr    = reg_wdata[30];
        m_frame = {32'hFFFF_FFFF, 2'b01, reg_wdata[30] ? 2'b01 : 2'b10,
                   reg_wdata[28:24], reg_wdata[20:16], 2'b10, reg_wdata[15:0]};
      end
    end
  end

  always @(negedge clk) begin
    int bi;
    bit e_oe;
    bi   = j / (2 * D);
    e_oe = m_busy && (m_wr || bi < 46);
    mdio_i <= (m_busy && !m_wr && bi >= 48) ? pat[63 - bi] : 1'b1;
    if (rst_n) begin
      chk("R3 busy", {31'd0, reg_rdata[31]}, {31'd0, m_busy});
      chk("R4 mdc", {31'd0, mdc}, {31'd0, m_busy ? 1'b1 & ((j / D) % 2 == 1) : 1'b0});
      chk("R6 oe", {31'd0, mdio_oe}, {31'd0, e_oe});
      if (e_oe) chk("R5 bit", {31'd0, mdio_o}, {31'd0, m_frame[63 - bi]});
    end
  end

  task automatic wr(logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 pins", {30'd0, mdc, mdio_oe}, 32'h0);
    rst_n = 1'b1;

    wr(32'h7FFF_FFFF);
    chk("R2 reserved", reg_rdata, 32'h5F1F_FFFF);
    chk("R3 no start", {31'd0, reg_rdata[31]}, 32'h0);

    wr(32'h4013_0000 | 32'h000A_A5C3 & 32'h001F_FFFF);
    wr(32'hC00A_A5C3 | 32'h0013_0000 | 32'h0300_0000);
    wait_idle();
    chk("R2 write fields", reg_rdata, 32'h430A_A5C3 | 32'h0013_0000);

    pat = 16'hB00F;
    wr(32'h0102_0000);
    wr(32'h8102_0000);
    repeat (40) @(negedge clk);
    wr(32'hC51F_1234);
    chk("R8 fields kept", {16'd0, reg_rdata[31:16]}, {16'd0, 16'h8102});
    wait_idle();
    chk("R7 read data", reg_rdata, 32'h0102_B00F);
    chk("R8 no restart", {31'd0, reg_rdata[31]}, 32'h0);

    pat = 16'h5A3C;
    wr(32'h9F1F_0000);
    while (!(m_busy && j == FRAME_CYC - 1)) @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 32'hC000_FFFF;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R8 end-edge busy", {31'd0, reg_rdata[31]}, 32'h0);
    chk("R8 end-edge fields", reg_rdata, 32'h1F1F_5A3C);
    @(negedge clk);
    chk("R7 second read", {16'd0, reg_rdata[15:0]}, 32'h0000_5A3C);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    while (cycles < 150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got=%0d exp=<150000", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule